// File: doc/BRIEF.md
# Pipelined Burst Synchronous SRAM Front End

This block is the clocked front end of a pipelined burst static RAM with byte-granular writes. It holds a small parameterised memory array. On every rising clock edge it samples two address strobes, a burst-advance input, five chip enables and a set of write enables. From these it decides whether the current cycle starts a burst, continues or suspends one, deselects the device, or does nothing. The low address bits of a burst come from a sequence generator that can count in linear order or in interleaved (XOR) order.

There are two strobes. A processor-side strobe always starts a read; a write at that address follows on the next edge. A controller-side strobe starts a read or a write, as the write enables decide. Read data passes through an array register and then an output register. The data bus is modelled as separate input and output ports. The output port carries a valid flag that stands for the bus being driven. A sleep input puts the device into power-down without losing its contents. Strobes that arrive inside the recovery window after sleep are rejected and flagged.

The state machine has four states. ST_IDLE means no burst is open. ST_BURST means a burst is open. ST_DOZE is power-down. ST_WAKE is recovery.

The transitions are:
- start: ST_IDLE or ST_BURST to ST_BURST, on a selected strobe.
- deselect: ST_IDLE or ST_BURST to ST_IDLE.
- continue or suspend: ST_BURST to ST_BURST, with both strobes high.
- doze: any state except ST_DOZE to ST_DOZE, when sleep is high.
- wake: ST_DOZE to ST_WAKE, when sleep is low.
- resume: ST_WAKE to ST_IDLE, when the recovery count expires.
- re-doze: ST_WAKE to ST_DOZE, when sleep is high again.

Top module: `sync_burst_sram`

## Requirements
- R1: The device counts as selected only when ce_n=0, ce_hi_a=1, ce_hi_b=1, ce_lo_a_n=0 and ce_lo_b_n=0. The chip enables are decoded only on edges where a strobe is taken. On continue or suspend edges they have no effect.
- R2: With ce_n=1, a low cpu_stb_n is ignored, so the edge behaves as if both strobes were high. A taken strobe with the device not selected deselects it: no access happens and the open burst is closed.
- R3: A low cpu_stb_n with the device selected starts a burst at addr with a read, whatever the write enables say.
- R4: A low ctl_stb_n with cpu_stb_n high and the device selected starts a burst at addr that reads or writes according to the write decode.
- R5: Write decode works as follows. gw_n=0 writes all bytes. Otherwise, bwe_n=0 writes each byte k whose bw_n[k]=0, which is wdata bits 8k+7 down to 8k. When no byte is enabled the cycle is a read.
- R6: Inside an open burst, with both strobes high, adv_n=0 moves to the next burst address and adv_n=1 stays at the current one. Either way the write decode picks read or write, so a write can follow a cpu_stb_n start.
- R7: For burst step n (n=0..3) from base low bits b, the two low address bits are (b+n) mod 4 when linear_mode=1 and b XOR n when linear_mode=0. The upper bits stay fixed.
- R8: A read taken at edge k shows its word on rdata with rdata_vld=1 after edge k+1.
- R9: rdata_vld is 0 while oe_n=1. It is also 0 after edge k+1 when edge k was a write, a deselect or an idle edge. rdata is zero whenever rdata_vld is 0. Both outputs are 0 after reset.
- R10: An edge that samples sleep=1 enters power-down. That edge and the edges that follow do no access, rdata_vld goes to 0 at once, and the array keeps its contents.
- R11: Two edges are in the recovery window: the first edge that samples sleep=0 after power-down, and the edge after it. A strobe on either edge is ignored and sets wake_strobe_err for the following cycle. A strobe on the next edge is served normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr | input | ADDR_W | External word address |
| cpu_stb_n | input | 1 | Processor-side address strobe, active low |
| ctl_stb_n | input | 1 | Controller-side address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| ce_n | input | 1 | Primary chip enable, active low, also masks cpu_stb_n |
| ce_hi_a | input | 1 | Chip enable, active high |
| ce_hi_b | input | 1 | Chip enable, active high |
| ce_lo_a_n | input | 1 | Chip enable, active low |
| ce_lo_b_n | input | 1 | Chip enable, active low |
| gw_n | input | 1 | Global write of all bytes, active low |
| bwe_n | input | 1 | Byte-group write enable, active low |
| bw_n | input | BYTES | Per-byte write enables, active low |
| oe_n | input | 1 | Output enable, active low |
| sleep | input | 1 | Power-down request |
| linear_mode | input | 1 | 1 selects linear burst order, 0 selects interleaved order |
| wdata | input | 8*BYTES | Write data |
| rdata | output | 8*BYTES | Read data, zero when not valid |
| rdata_vld | output | 1 | Read data is being driven |
| wake_strobe_err | output | 1 | A strobe was rejected inside the recovery window |

## Verification
Two situations put two functions into the same cycle. In the first, a processor strobe is masked by ce_n=1 on the same edge that a burst continues; that edge also drives inactive enables, which must be ignored. The bench provokes this and judges it by the word read back: it must be the next burst address, not the strobe's address. In the second, a read result is still in the output pipeline when sleep is raised on the next edge. The bench judges this by rdata_vld dropping at once. Only after the recovery edges have gone by, with their strobes flagged, does a fresh read return the data stored before sleep.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BURST = 2'd1,
        ST_DOZE  = 2'd2,
        ST_WAKE  = 2'd3
    } sbs_state_e;

    typedef enum logic [1:0] {
        OP_NONE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2
    } sbs_op_e;

endpackage

// File: rtl/sbs_ctrl_fsm.sv
module sbs_ctrl_fsm
    import sbs_pkg::*;
#(
    parameter int BYTES      = 8,
    parameter int REC_CYCLES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_stb_n,
    input  logic             ctl_stb_n,
    input  logic             adv_n,
    input  logic             ce_n,
    input  logic             ce_hi_a,
    input  logic             ce_hi_b,
    input  logic             ce_lo_a_n,
    input  logic             ce_lo_b_n,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [BYTES-1:0] bw_n,
    input  logic             sleep,
    output sbs_op_e          op,
    output logic [BYTES-1:0] wmask,
    output logic             load,
    output logic             advance,
    output logic             wake_err,
    output sbs_state_e       state_o
);

    localparam int CNT_W = (REC_CYCLES > 2) ? $clog2(REC_CYCLES) : 1;

    sbs_state_e       state_q, state_d;
    logic [CNT_W-1:0] rec_q, rec_d;
    logic             sel_all, cpu_hit, raw_strobe, wr_dec;
    logic [BYTES-1:0] wdec;

    // Select and write decode shared by all states.
    always_comb begin
        sel_all    = !ce_n && ce_hi_a && ce_hi_b && !ce_lo_a_n && !ce_lo_b_n;
        cpu_hit    = !cpu_stb_n && !ce_n;
        raw_strobe = !cpu_stb_n || !ctl_stb_n;
        if (!gw_n)       wdec = '1;
        else if (!bwe_n) wdec = ~bw_n;
        else             wdec = '0;
        wr_dec = |wdec;
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            rec_q   <= '0;
        end else begin
            state_q <= state_d;
            rec_q   <= rec_d;
        end
    end

    // Next state and outputs.
    always_comb begin
        state_d  = state_q;
        rec_d    = rec_q;
        op       = OP_NONE;
        load     = 1'b0;
        advance  = 1'b0;
        wake_err = 1'b0;
        unique case (state_q)
            ST_IDLE, ST_BURST: begin
                if (sleep) begin
                    state_d = ST_DOZE;
                end else if (cpu_hit) begin
                    if (sel_all) begin
                        load    = 1'b1;
                        op      = OP_READ;
                        state_d = ST_BURST;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (!ctl_stb_n) begin
                    if (sel_all) begin
                        load    = 1'b1;
                        op      = wr_dec ? OP_WRITE : OP_READ;
                        state_d = ST_BURST;
                    end else begin
                        state_d = ST_IDLE;
                    end
                end else if (state_q == ST_BURST) begin
                    advance = !adv_n;
                    op      = wr_dec ? OP_WRITE : OP_READ;
                end
            end
            ST_DOZE: begin
                if (!sleep) begin
                    wake_err = raw_strobe;
                    state_d  = ST_WAKE;
                    rec_d    = CNT_W'(REC_CYCLES - 2);
                end
            end
            ST_WAKE: begin
                if (sleep) begin
                    state_d = ST_DOZE;
                end else begin
                    wake_err = raw_strobe;
                    if (rec_q == '0) state_d = ST_IDLE;
                    else             rec_d   = rec_q - 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign wmask   = (op == OP_WRITE) ? wdec : '0;
    assign state_o = state_q;

    // R3: a selected processor strobe leaves a burst open on the next cycle.
    p_cpu_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_BURST) && !sleep && !cpu_stb_n && sel_all)
        |=> (state_q == ST_BURST));

    // R2: a taken strobe while not selected closes the burst.
    p_deselect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_IDLE || state_q == ST_BURST) && !sleep && !ctl_stb_n && !sel_all)
        |=> (state_q == ST_IDLE));

endmodule

// File: rtl/sbs_burst_seq.sv
module sbs_burst_seq #(
    parameter int ADDR_W  = 8,
    parameter int BURST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              advance,
    input  logic              linear,
    input  logic [ADDR_W-1:0] ext_addr,
    output logic [ADDR_W-1:0] acc_addr
);

    logic [ADDR_W-1:BURST_W]  hi_q, hi_sel;
    logic [BURST_W-1:0]       base_q, base_sel, cnt_q, cnt_nxt, lo;

    always_comb begin
        hi_sel   = load ? ext_addr[ADDR_W-1:BURST_W] : hi_q;
        base_sel = load ? ext_addr[BURST_W-1:0] : base_q;
        if (load)         cnt_nxt = '0;
        else if (advance) cnt_nxt = cnt_q + 1'b1;
        else              cnt_nxt = cnt_q;
        lo = linear ? (base_sel + cnt_nxt) : (base_sel ^ cnt_nxt);
    end

    assign acc_addr = {hi_sel, lo};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q   <= '0;
            base_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (load) begin
                hi_q   <= ext_addr[ADDR_W-1:BURST_W];
                base_q <= ext_addr[BURST_W-1:0];
            end
            cnt_q <= cnt_nxt;
        end
    end

    // R7: a linear step moves the low bits up by one.
    p_linear_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !load && linear && $past(linear))
        |-> (acc_addr[BURST_W-1:0] == BURST_W'($past(acc_addr[BURST_W-1:0]) + 1'b1)));

    // R6: suspend keeps the access address.
    p_suspend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!advance && !load && $stable(linear)) |-> $stable(acc_addr));

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 8,
    parameter int BYTES  = 8
) (
    input  logic               clk,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               re,
    input  logic               we,
    input  logic [BYTES-1:0]   wmask,
    input  logic [8*BYTES-1:0] wdata,
    output logic [8*BYTES-1:0] rd_q
);

    localparam int DEPTH = 2 ** ADDR_W;

    for (genvar g = 0; g < BYTES; g++) begin : g_lane
        logic [7:0] lane_mem [DEPTH];
        always_ff @(posedge clk) begin
            if (we && wmask[g]) lane_mem[addr] <= wdata[g*8 +: 8];
            if (re)             rd_q[g*8 +: 8] <= lane_mem[addr];
        end
    end

endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
    import sbs_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int BYTES      = 8,
    parameter int BURST_W    = 2,
    parameter int REC_CYCLES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               cpu_stb_n,
    input  logic               ctl_stb_n,
    input  logic               adv_n,
    input  logic               ce_n,
    input  logic               ce_hi_a,
    input  logic               ce_hi_b,
    input  logic               ce_lo_a_n,
    input  logic               ce_lo_b_n,
    input  logic               gw_n,
    input  logic               bwe_n,
    input  logic [BYTES-1:0]   bw_n,
    input  logic               oe_n,
    input  logic               sleep,
    input  logic               linear_mode,
    input  logic [8*BYTES-1:0] wdata,
    output logic [8*BYTES-1:0] rdata,
    output logic               rdata_vld,
    output logic               wake_strobe_err
);

    localparam int DATA_W = 8 * BYTES;

    sbs_op_e           op;
    sbs_state_e        state;
    logic [BYTES-1:0]  wmask;
    logic              load, advance, wake_set, arr_re, arr_we;
    logic [ADDR_W-1:0] acc_addr;
    logic [DATA_W-1:0] arr_q, out_q;
    logic              rd_pend_q, out_vld_q, wake_err_q;

    sbs_ctrl_fsm #(.BYTES(BYTES), .REC_CYCLES(REC_CYCLES)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
        .ce_n(ce_n), .ce_hi_a(ce_hi_a), .ce_hi_b(ce_hi_b),
        .ce_lo_a_n(ce_lo_a_n), .ce_lo_b_n(ce_lo_b_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .sleep(sleep),
        .op(op), .wmask(wmask), .load(load), .advance(advance),
        .wake_err(wake_set), .state_o(state)
    );

    sbs_burst_seq #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .load(load), .advance(advance),
        .linear(linear_mode), .ext_addr(addr), .acc_addr(acc_addr)
    );

    assign arr_re = (op == OP_READ);
    assign arr_we = (op == OP_WRITE);

    sbs_array #(.ADDR_W(ADDR_W), .BYTES(BYTES)) u_arr (
        .clk(clk), .addr(acc_addr), .re(arr_re), .we(arr_we),
        .wmask(wmask), .wdata(wdata), .rd_q(arr_q)
    );

    // Output pipeline: array register, then output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_pend_q  <= 1'b0;
            out_vld_q  <= 1'b0;
            out_q      <= '0;
            wake_err_q <= 1'b0;
        end else begin
            rd_pend_q  <= arr_re;
            out_vld_q  <= rd_pend_q;
            wake_err_q <= wake_set;
            if (rd_pend_q) out_q <= arr_q;
        end
    end

    assign rdata_vld       = out_vld_q && !oe_n && (state != ST_DOZE);
    assign rdata           = rdata_vld ? out_q : '0;
    assign wake_strobe_err = wake_err_q;

    // R8: driven data always comes from a read two edges back.
    p_read_latency_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rdata_vld |-> $past(arr_re, 2));

    // R9: output enable high keeps the bus undriven.
    p_oe_hiz_r9: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n |-> !rdata_vld);

    // R10: a sampled sleep request blocks any array access.
    p_sleep_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        sleep |-> (!arr_re && !arr_we));

    // R11: a flagged strobe caused no access.
    p_wake_reject_r11: assert property (@(posedge clk) disable iff (!rst_n)
        wake_strobe_err |-> $past(!arr_re && !arr_we));

endmodule

// File: tb/sim_sync_burst_sram.sv
module sim_sync_burst_sram;

    localparam int CLK_P = 10;
    localparam int AW    = 8;
    localparam int NB    = 8;
    localparam int DW    = 8 * NB;

    logic          clk = 1'b0;
    logic          rst_n;
    logic [AW-1:0] addr;
    logic          cpu_stb_n, ctl_stb_n, adv_n;
    logic          ce_n, ce_hi_a, ce_hi_b, ce_lo_a_n, ce_lo_b_n;
    logic          gw_n, bwe_n, oe_n, sleep, linear_mode;
    logic [NB-1:0] bw_n;
    logic [DW-1:0] wdata, rdata;
    logic          rdata_vld, wake_strobe_err;

    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;
    logic [DW-1:0] ref_mem [256];

    always #(CLK_P/2) clk = ~clk;

    sync_burst_sram u0 (
        .clk(clk), .rst_n(rst_n), .addr(addr),
        .cpu_stb_n(cpu_stb_n), .ctl_stb_n(ctl_stb_n), .adv_n(adv_n),
        .ce_n(ce_n), .ce_hi_a(ce_hi_a), .ce_hi_b(ce_hi_b),
        .ce_lo_a_n(ce_lo_a_n), .ce_lo_b_n(ce_lo_b_n),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n), .oe_n(oe_n),
        .sleep(sleep), .linear_mode(linear_mode), .wdata(wdata),
        .rdata(rdata), .rdata_vld(rdata_vld), .wake_strobe_err(wake_strobe_err)
    );

    function automatic logic [DW-1:0] pat(input logic [7:0] a);
        return 64'h0123_4567_89AB_CDEF ^ {8{a}};
    endfunction

    task automatic chk(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_in();
        cpu_stb_n = 1'b1; ctl_stb_n = 1'b1; adv_n = 1'b1;
        ce_n = 1'b0; ce_hi_a = 1'b1; ce_hi_b = 1'b1; ce_lo_a_n = 1'b0; ce_lo_b_n = 1'b0;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = '1; oe_n = 1'b0; wdata = '0;
    endtask

    task automatic desel();
        ctl_stb_n = 1'b0; ce_n = 1'b1;
        tick();
        idle_in();
    endtask

    task automatic wr_c(input logic [7:0] a, input logic [DW-1:0] d,
                        input bit glob, input logic [NB-1:0] bmask);
        ctl_stb_n = 1'b0; addr = a; wdata = d;
        if (glob) gw_n = 1'b0;
        else begin bwe_n = 1'b0; bw_n = ~bmask; end
        tick();
        for (int b = 0; b < NB; b++)
            if (glob || bmask[b]) ref_mem[a][b*8 +: 8] = d[b*8 +: 8];
        idle_in();
        desel();
    endtask

    task automatic rd_c(input logic [7:0] a);
        ctl_stb_n = 1'b0; addr = a;
        tick();
        idle_in();
    endtask

    task automatic read_check(input string req, input logic [7:0] a);
        rd_c(a);
        desel();
        chk({req, " valid"}, DW'(rdata_vld), DW'(1));
        chk({req, " data"}, rdata, ref_mem[a]);
    endtask

    task automatic t_reset();
        chk("R9 reset valid", DW'(rdata_vld), DW'(0));
        chk("R9 reset data", rdata, '0);
        chk("R11 reset flag", DW'(wake_strobe_err), DW'(0));
    endtask

    task automatic t_global_write();
        wr_c(8'h10, pat(8'h10), 1'b1, '0);
        read_check("R4 R5 R8 global write", 8'h10);
        oe_n = 1'b1; #1;
        chk("R9 oe_n high", DW'(rdata_vld), DW'(0));
        oe_n = 1'b0; #1;
        chk("R9 oe_n low again", DW'(rdata_vld), DW'(1));
        tick();
        chk("R9 after deselect", DW'(rdata_vld), DW'(0));
    endtask

    task automatic t_byte_write();
        wr_c(8'h10, '1, 1'b0, 8'b0010_0001);
        read_check("R5 byte lanes 0 and 5", 8'h10);
        // R5: bw_n low but bwe_n high decodes as a read
        ctl_stb_n = 1'b0; addr = 8'h10; bw_n = '0; wdata = '0;
        tick();
        idle_in();
        desel();
        chk("R5 bwe_n high reads", rdata, ref_mem[8'h10]);
    endtask

    task automatic t_cpu_strobe();
        cpu_stb_n = 1'b0; addr = 8'h10; gw_n = 1'b0; wdata = '0;
        tick();
        idle_in();
        desel();
        chk("R3 cpu strobe reads", rdata, ref_mem[8'h10]);
        read_check("R3 no write on cpu strobe", 8'h10);
        cpu_stb_n = 1'b0; addr = 8'h20;
        tick();
        idle_in();
        gw_n = 1'b0; wdata = pat(8'h20);
        tick();
        ref_mem[8'h20] = pat(8'h20);
        idle_in();
        desel();
        chk("R9 write cycle undriven", DW'(rdata_vld), DW'(0));
        read_check("R6 write after cpu strobe", 8'h20);
    endtask

    task automatic t_burst(input bit lin, input string req);
        logic [7:0] exp_a;
        linear_mode = lin;
        rd_c(8'h31);
        adv_n = 1'b0;
        for (int n = 0; n < 4; n++) begin
            if (n == 3) begin ctl_stb_n = 1'b0; ce_n = 1'b1; end
            tick();
            exp_a = lin ? {6'b001100, 2'(2'b01 + 2'(n))} : {6'b001100, 2'(2'b01 ^ 2'(n))};
            chk(req, rdata, ref_mem[exp_a]);
        end
        idle_in();
        linear_mode = 1'b1;
    endtask

    task automatic t_suspend();
        rd_c(8'h32);
        tick();
        chk("R6 suspend first", rdata, ref_mem[8'h32]);
        adv_n = 1'b0;
        tick();
        chk("R6 suspend held", rdata, ref_mem[8'h32]);
        idle_in();
        desel();
        chk("R6 advance after suspend", rdata, ref_mem[8'h33]);
    endtask

    task automatic t_enables();
        ctl_stb_n = 1'b0; addr = 8'h30; ce_hi_a = 1'b0;
        tick();
        idle_in();
        tick();
        chk("R1 unselected start no read", DW'(rdata_vld), DW'(0));
        rd_c(8'h30);
        cpu_stb_n = 1'b0; ce_n = 1'b1; ce_hi_b = 1'b0; addr = 8'h10; adv_n = 1'b0;
        tick();
        idle_in();
        chk("R1 R2 masked strobe first word", rdata, ref_mem[8'h30]);
        desel();
        chk("R2 masked strobe continues burst", rdata, ref_mem[8'h31]);
        rd_c(8'h30);
        cpu_stb_n = 1'b0; ce_lo_a_n = 1'b1; addr = 8'h33;
        tick();
        idle_in();
        chk("R2 read before deselect", rdata, ref_mem[8'h30]);
        tick();
        chk("R2 cpu strobe deselects", DW'(rdata_vld), DW'(0));
    endtask

    task automatic t_sleep();
        wr_c(8'h40, pat(8'h40), 1'b1, '0);
        rd_c(8'h40);
        sleep = 1'b1;
        tick();
        chk("R10 output off at sleep", DW'(rdata_vld), DW'(0));
        ctl_stb_n = 1'b0; gw_n = 1'b0; addr = 8'h40; wdata = '0;
        tick();
        idle_in();
        chk("R11 no flag while asleep", DW'(wake_strobe_err), DW'(0));
        tick();
        sleep = 1'b0; ctl_stb_n = 1'b0; addr = 8'h40;
        tick();
        chk("R11 wake edge strobe flagged", DW'(wake_strobe_err), DW'(1));
        chk("R11 wake edge no output", DW'(rdata_vld), DW'(0));
        tick();
        chk("R11 recovery edge strobe flagged", DW'(wake_strobe_err), DW'(1));
        tick();
        chk("R11 strobe after recovery accepted", DW'(wake_strobe_err), DW'(0));
        idle_in();
        desel();
        chk("R10 R11 contents kept valid", DW'(rdata_vld), DW'(1));
        chk("R10 contents kept", rdata, pat(8'h40));
    endtask

    initial begin
        #(CLK_P * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual no completion expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; sleep = 1'b0; linear_mode = 1'b1; addr = '0;
        idle_in();
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_global_write();
        t_byte_write();
        t_cpu_strobe();
        wr_c(8'h30, pat(8'h30), 1'b1, '0);
        wr_c(8'h31, pat(8'h31), 1'b1, '0);
        wr_c(8'h32, pat(8'h32), 1'b1, '0);
        wr_c(8'h33, pat(8'h33), 1'b1, '0);
        t_burst(1'b1, "R6 R7 linear burst");
        t_burst(1'b0, "R7 interleaved burst");
        t_suspend();
        t_enables();
        t_sleep();
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule